// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Controller

This block sits beside the execute stage of a processor core. It runs the handshake with the attached coprocessors. The execute stage presents a candidate coprocessor instruction on a valid/ready port, together with its 4-bit condition code and the current N, Z, C and V flags. If the condition passes and no flush is pending, the block drives the active-low instruction strobe `cp_instr_n` to every coprocessor. It then looks at the shared `cp_absent` and `cp_busy` lines on every rising clock edge and settles the outcome. An absent response raises a trap request. A busy response stalls the core. When neither line is high, the coprocessor has accepted the instruction and the block pulses `commit`.

Back-pressure rules for the issue port:
- An item transfers on a rising edge where `issue_valid` and `issue_ready` are both high.
- `issue_ready` is high only while no handshake is outstanding.
- A valid that arrives while ready is low is not taken.
- A transferred item whose condition fails, or that arrives together with `flush`, is consumed without any effect.

A busy coprocessor can hold the core for any number of cycles. A flush ends that wait at once and produces no outcome.

Top module: `cp_handshake_ctrl`

## Requirements
- R1: After reset, `cp_instr_n` is 1, `stall`, `trap_req` and `commit` are 0, and `issue_ready` is 1.
- R2: An issue transfers when `issue_valid` and `issue_ready` are both high at a rising edge. If it passes its condition and `flush` is low, `cp_instr_n` is 0 from that edge on. `issue_ready` is 0 for as long as `cp_instr_n` is 0.
- R3: Condition codes map as follows, with the flags input ordered [3]=N, [2]=Z, [1]=C, [0]=V:
  - 0 passes when Z is set; 1 passes when Z is clear.
  - 2 passes when C is set; 3 passes when C is clear.
  - 4 passes when N is set; 5 passes when N is clear.
  - 6 passes when V is set; 7 passes when V is clear.
  - 8 passes when C is set and Z is clear; 9 is the inverse of 8.
  - 10 passes when N equals V; 11 passes when N differs from V.
  - 12 passes when Z is clear and N equals V; 13 is the inverse of 12.
  - 14 always passes.
  - An issue whose condition fails leaves `cp_instr_n` at 1 and gives no stall, trap or commit.
- R4: Condition code 15 marks the extended forms. These skip the flag check and always issue.
- R5: While `cp_instr_n` is 1, `cp_absent` and `cp_busy` are ignored: `stall`, `trap_req` and `commit` stay 0.
- R6: If `cp_absent` is 1 at an edge where `cp_instr_n` is 0 and `flush` is 0, `trap_req` is 1 for exactly the following cycle and `cp_instr_n` returns to 1.
- R7: `stall` is 1, combinationally, in each cycle where `cp_instr_n` is 0, `cp_busy` is 1, and `cp_absent` and `flush` are 0. `cp_instr_n` stays 0 after such a cycle. The number of stall cycles therefore equals the number of busy cycles the coprocessor returns.
- R8: If `cp_absent` and `cp_busy` are both 0 at an edge where `cp_instr_n` is 0 and `flush` is 0, `commit` is 1 for exactly the following cycle and `cp_instr_n` returns to 1.
- R9: `flush` cancels the handshake. Raised while `cp_instr_n` is 0, it returns `cp_instr_n` to 1 at the next edge with no trap or commit. Raised with an issue, it prevents `cp_instr_n` from falling.
- R10: `cp_absent` takes priority over `cp_busy`. When both are 1, the result is a trap with no stall cycle. At most one of `stall`, `trap_req` and `commit` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Execute stage offers a coprocessor instruction |
| issue_ready | output | 1 | Block can take an issue (idle) |
| issue_cond | input | 4 | Condition code of the offered instruction |
| flags_nzcv | input | 4 | Current flags, [3]=N [2]=Z [1]=C [0]=V |
| flush | input | 1 | Pipeline flush or interrupt; cancels the handshake |
| cp_instr_n | output | 1 | Active-low coprocessor instruction strobe |
| cp_absent | input | 1 | No coprocessor recognises the instruction |
| cp_busy | input | 1 | A coprocessor will accept, but not yet |
| stall | output | 1 | Hold the execute stage this cycle |
| trap_req | output | 1 | One-cycle undefined-instruction trap request |
| commit | output | 1 | One-cycle pulse: the coprocessor accepted |

## Verification
The coprocessor model replies with a programmable busy count and absent flag.
- Busy counts of 0, 1, 2, 3 and 40 separate an immediate commit from one that follows an exact number of stall cycles.
- Absent alone, and absent together with busy, show that the trap wins and never stalls.
- Passing and failing flag patterns for several condition codes, plus code 15 with all flags clear, distinguish a skipped instruction from an issued one.
- Noise on the response lines while the strobe is high, a flush in the middle of a busy wait, and a flush that coincides with the issue show that idle responses are ignored and that a cancel yields no outcome.

// File: rtl/cp_hs_pkg.sv
package cp_hs_pkg;
  localparam int COND_W = 4;
  localparam int FLAG_W = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
  localparam logic [COND_W-1:0] COND_EXT = 4'hF;

  typedef enum logic {HS_IDLE = 1'b0, HS_WAIT = 1'b1} hs_state_t;
endpackage

// File: rtl/cp_cond_check.sv
module cp_cond_check
  import cp_hs_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  logic n, z, c, v, base;

  assign n = flags[FLG_N];
  assign z = flags[FLG_Z];
  assign c = flags[FLG_C];
  assign v = flags[FLG_V];

  // Even codes test a predicate; the odd code above it inverts it (R3).
  always_comb begin
    unique case (cond[COND_W-1:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
  end

  // Code 14 always passes; code 15 is the extended form (R4).
  assign pass = (cond[COND_W-1:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
endmodule

// File: rtl/cp_hs_fsm.sv
module cp_hs_fsm
  import cp_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic cond_ok,
  input  logic flush,
  input  logic absent,
  input  logic busy,
  output logic idle,
  output logic strobe_n,
  output logic stall,
  output logic trap_req,
  output logic commit
);
  hs_state_t state_q;
  logic      trap_q, commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HS_IDLE;
      trap_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      trap_q   <= 1'b0;
      commit_q <= 1'b0;
      unique case (state_q)
        HS_IDLE: if (take && cond_ok && !flush) state_q <= HS_WAIT;
        HS_WAIT: begin
          if (flush) begin
            state_q <= HS_IDLE;
          end else if (absent) begin
            trap_q  <= 1'b1;
            state_q <= HS_IDLE;
          end else if (!busy) begin
            commit_q <= 1'b1;
            state_q  <= HS_IDLE;
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign idle     = (state_q == HS_IDLE);
  assign strobe_n = (state_q != HS_WAIT);
  assign stall    = (state_q == HS_WAIT) && !flush && !absent && busy;
  assign trap_req = trap_q;
  assign commit   = commit_q;

  assert_trap_on_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && absent && !flush) |=> (trap_req && strobe_n && !commit));
  assert_commit_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !absent && !busy && !flush) |=> (commit && strobe_n && !trap_req));
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !strobe_n);
  assert_flush_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && flush) |=> (strobe_n && !trap_req && !commit));
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |-> !stall);
  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, trap_req, commit}));
  assert_no_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !idle);
endmodule

// File: rtl/cp_handshake_ctrl.sv
module cp_handshake_ctrl
  import cp_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [COND_W-1:0] issue_cond,
  input  logic [FLAG_W-1:0] flags_nzcv,
  input  logic              flush,
  output logic              cp_instr_n,
  input  logic              cp_absent,
  input  logic              cp_busy,
  output logic              stall,
  output logic              trap_req,
  output logic              commit
);
  logic cond_ok, idle, take;

  assign take        = issue_valid && idle;
  assign issue_ready = idle;

  cp_cond_check u_cond (
    .cond  (issue_cond),
    .flags (flags_nzcv),
    .pass  (cond_ok)
  );

  cp_hs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .cond_ok  (cond_ok),
    .flush    (flush),
    .absent   (cp_absent),
    .busy     (cp_busy),
    .idle     (idle),
    .strobe_n (cp_instr_n),
    .stall    (stall),
    .trap_req (trap_req),
    .commit   (commit)
  );

  assert_ext_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && issue_cond == COND_EXT && !flush) |=> !cp_instr_n);
endmodule

// File: tb/test_cp_handshake_ctrl.sv
`timescale 1ns/100ps
module test_cp_handshake_ctrl;
  localparam int K_TRAP = 1, K_COMMIT = 2, K_CANCEL = 3, K_NONE = 0;

  typedef struct {
    int    kind;
    int    stalls;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0, flush = 1'b0;
  logic [3:0] issue_cond = 4'hE, flags_nzcv = 4'h0;
  logic issue_ready, cp_instr_n, cp_absent, cp_busy, stall, trap_req, commit;

  logic noise_abs = 1'b0, noise_busy = 1'b0, absent_cfg = 1'b0;
  int   busy_cfg = 0, used = 0;
  int   checks = 0, fails = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  // Coprocessor model: busy for busy_cfg strobe cycles, optional absent.
  always @(posedge clk) used <= cp_instr_n ? 0 : used + 1;
  assign cp_absent = noise_abs | (!cp_instr_n && absent_cfg);
  assign cp_busy   = noise_busy | (!cp_instr_n && (used < busy_cfg));

  cp_handshake_ctrl i_cp_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_cond(issue_cond), .flags_nzcv(flags_nzcv), .flush(flush),
    .cp_instr_n(cp_instr_n), .cp_absent(cp_absent), .cp_busy(cp_busy),
    .stall(stall), .trap_req(trap_req), .commit(commit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Monitor: measures each strobe episode and compares with the scoreboard.
  initial begin
    bit in_ep = 0;
    int st = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (cp_instr_n && stall) chk(0, "R5 stall while strobe high", 1, 0);
        if (!cp_instr_n) begin
          in_ep = 1;
          if (stall) st++;
        end else if (in_ep) begin
          int k;
          exp_t e;
          k = trap_req ? K_TRAP : (commit ? K_COMMIT : K_CANCEL);
          if (sb.size() == 0) chk(0, "unexpected episode", k, K_NONE);
          else begin
            e = sb.pop_front();
            chk(k == e.kind, {e.req, " outcome"}, k, e.kind);
            chk(st == e.stalls, {e.req, " stall cycles"}, st, e.stalls);
          end
          in_ep = 0;
          st = 0;
        end else if (trap_req || commit) begin
          chk(0, "R5 outcome without strobe", 1, 0);
        end
      end
    end
  end

  task automatic do_issue(input logic [3:0] cond, input logic [3:0] fl,
                          input bit absent, input int busy, input int flush_at,
                          input int kind, input int stalls, input string req);
    @(negedge clk);
    issue_cond = cond; flags_nzcv = fl; issue_valid = 1'b1;
    absent_cfg = absent; busy_cfg = busy;
    flush = (flush_at == 0);
    if (kind != K_NONE) sb.push_back('{kind, stalls, req});
    @(negedge clk);
    issue_valid = 1'b0; flush = 1'b0;
    #1;
    if (kind == K_NONE) begin
      chk(cp_instr_n == 1'b1, {req, " no strobe"}, cp_instr_n, 1);
    end else begin
      chk(cp_instr_n == 1'b0, "R2 strobe after issue", cp_instr_n, 0);
      chk(issue_ready == 1'b0, "R2 ready low during handshake", issue_ready, 0);
    end
    if (flush_at > 0) begin
      repeat (flush_at) @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
    end
    repeat (busy + 3) @(negedge clk);
    #1;
    chk(cp_instr_n && !trap_req && !commit, {req, " quiet after"}, cp_instr_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cp_instr_n == 1'b1, "R1 strobe", cp_instr_n, 1);
    chk(!stall && !trap_req && !commit, "R1 outcomes", {stall, trap_req, commit}, 0);
    chk(issue_ready == 1'b1, "R1 ready", issue_ready, 1);
    rst_n = 1'b1;

    // R5: response lines toggled while idle
    @(negedge clk);
    noise_abs = 1'b1; noise_busy = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!stall && !trap_req && !commit && cp_instr_n, "R5 idle noise",
          {stall, trap_req, commit}, 0);
    end
    noise_abs = 1'b0; noise_busy = 1'b0;

    do_issue(4'hE, 4'h0, 0, 0, -1, K_COMMIT, 0, "R8 immediate commit");
    do_issue(4'hE, 4'h0, 0, 3, -1, K_COMMIT, 3, "R7 busy 3");
    do_issue(4'hE, 4'h0, 1, 0, -1, K_TRAP, 0, "R6 absent trap");
    do_issue(4'hE, 4'h0, 1, 4, -1, K_TRAP, 0, "R10 absent over busy");
    do_issue(4'hE, 4'h0, 0, 5, 2, K_CANCEL, 2, "R9 flush during busy");
    do_issue(4'hE, 4'h0, 0, 0, 0, K_NONE, 0, "R9 flush with issue");
    do_issue(4'h0, 4'b0100, 0, 0, -1, K_COMMIT, 0, "R3 EQ pass");
    do_issue(4'h0, 4'b0000, 0, 0, -1, K_NONE, 0, "R3 EQ fail");
    do_issue(4'hA, 4'b1001, 0, 0, -1, K_COMMIT, 0, "R3 GE pass");
    do_issue(4'hB, 4'b1001, 0, 0, -1, K_NONE, 0, "R3 LT fail");
    do_issue(4'h8, 4'b0010, 0, 1, -1, K_COMMIT, 1, "R3 HI pass");
    do_issue(4'h9, 4'b0010, 0, 0, -1, K_NONE, 0, "R3 LS fail");
    do_issue(4'hC, 4'b0100, 0, 0, -1, K_NONE, 0, "R3 GT fail");
    do_issue(4'hF, 4'b0000, 0, 2, -1, K_COMMIT, 2, "R4 extended form");
    do_issue(4'hE, 4'h0, 0, 40, -1, K_COMMIT, 40, "R7 busy 40");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule